// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block is the device side of a byte-wide parallel EEPROM, with the storage array held in flip-flops. It samples three active-low strobes (chip enable, output enable, write enable) on the system clock. A write strobe loads one byte into a page buffer. Later strobes to the same page add bytes to it. When the host has issued no new write strobe for a set number of cycles, the block runs a timed programming phase. At the end of that phase it copies every loaded byte into the array in one step.

While the programming phase runs, reads do not return array data. They return a status byte instead. Bit 7 of that byte is the complement of bit 7 of the last byte loaded. Bit 6 inverts on every read access. Software can poll either bit to detect completion. All real-time limits are parameters counted in clock cycles: the shortest valid write pulse, the page-load window and the programming time.

Top module: `eeprom_page_seq`

## Requirements
- R1: A byte is loaded only while ce_ni and we_ni are both low and oe_ni is high. A strobe with oe_ni low, or with ce_ni high, changes no array byte.
- R2: The byte address is the addr_i value sampled on the first clock edge of the write overlap. The stored data is the last wdata_i value sampled while the overlap lasts.
- R3: An overlap sampled on fewer than MIN_PULSE clock edges loads nothing and does not start programming. An overlap of exactly MIN_PULSE edges is accepted.
- R4: addr_i[6:0] selects the byte within a page and the upper address bits select the page. All bytes loaded into one page are committed together, and the other bytes of that page keep their values.
- R5: busy_o rises on the WINDOW-th clock edge that samples the write condition inactive after the last write overlap. A new overlap before then restarts the count.
- R6: busy_o stays high for exactly PROG_CYC clock cycles. Reads after it falls return the committed data.
- R7: While busy_o is high, a read returns bit 7 equal to the complement of bit 7 of the last accepted byte, and bits 5:0 equal to zero.
- R8: While busy_o is high, bit 6 of the first read access is 1 and inverts on each later access. After busy_o falls, repeated reads return identical array data.
- R9: rdata_oe_o is high in the cycle after a clock edge that samples ce_ni and oe_ni both low. Otherwise it is low. It is low after reset.
- R10: A byte whose page differs from the page of the first byte of the current load is dropped and sets page_err_o. page_err_o stays set until reset.
- R11: Write strobes during programming are ignored and do not alter the array.
- R12: While pwr_ok_i is low, write strobes load nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply good; low blocks writes |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data or status |
| rdata_oe_o | output | 1 | Read data valid, bus driven |
| busy_o | output | 1 | Programming phase in progress |
| page_err_o | output | 1 | Sticky page-mismatch flag |

## Verification
A wrong sequencer state shows up at busy_o. It rises one cycle early or late, or it stays high for a different length, and the bench measures both edges to the cycle. A corrupted page buffer or page address only becomes visible after busy_o falls, when reads of the committed page return wrong bytes or overwrite neighbours. A stale toggle or status register shows up on the very first status read, because the expected status pattern is fixed for each read access.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } seq_st_e;
endpackage

// File: rtl/eep_wr_strobe.sv
module eep_wr_strobe
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MIN_PULSE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              act_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_PULSE);

  logic              act, act_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign act = pwr_ok_i & ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      // address latched when the overlap opens
      if (act && !act_q) begin
        addr_q <= addr_i;
        cnt_q  <= CW'(1);
      end else if (act && cnt_q != MIN_V) begin
        cnt_q <= cnt_q + CW'(1);
      end
      // data follows the bus until the overlap closes
      if (act) data_q <= data_i;
    end
  end

  assign act_o  = act;
  assign done_o = act_q & ~act & (cnt_q == MIN_V);
  assign addr_o = addr_q;
  assign data_o = data_q;

  // R12
  no_write_unpowered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(pwr_ok_i));
endmodule

// File: rtl/eep_seq_ctrl.sv
module eep_seq_ctrl
  import eep_pkg::*;
#(
  parameter int WINDOW   = 40,
  parameter int PROG_CYC = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic done_i,
  output logic loading_o,
  output logic busy_o,
  output logic commit_o
);
  localparam int WW = $clog2(WINDOW + 1);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam logic [WW-1:0] WIN_MAX  = WW'(WINDOW);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW - 1);
  localparam logic [PW-1:0] PRG_LAST = PW'(PROG_CYC - 1);

  seq_st_e       st_q;
  logic [WW-1:0] win_q;
  logic [PW-1:0] prg_q;
  logic          prg_end;

  assign prg_end = (st_q == ST_PROG) && (prg_q == PRG_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      win_q <= '0;
      prg_q <= '0;
    end else begin
      // every write overlap re-arms the load window
      if (act_i) win_q <= '0;
      else if (win_q != WIN_MAX) win_q <= win_q + WW'(1);

      prg_q <= (st_q == ST_PROG) ? prg_q + PW'(1) : '0;

      unique case (st_q)
        ST_IDLE: if (done_i) st_q <= ST_LOAD;
        ST_LOAD: if (!act_i && win_q >= WIN_LAST) st_q <= ST_PROG;
        ST_PROG: if (prg_end) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign loading_o = (st_q == ST_LOAD);
  assign busy_o    = (st_q == ST_PROG);
  assign commit_o  = prg_end;

  // R5
  prog_after_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!act_i));
  // R6
  prog_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> prg_q <= PRG_LAST);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
  import eep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  accept_i,
  input  logic                                  loading_i,
  input  logic                                  busy_i,
  input  logic                                  commit_i,
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic [DATA_W-1:0]                     data_i,
  output logic [ADDR_W-PAGE_W-1:0]              page_o,
  output logic [(1<<PAGE_W)-1:0]                valid_o,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]    bytes_o,
  output logic                                  last_b7_o,
  output logic                                  err_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;

  logic [PG_W-1:0]   page_q;
  logic              last_b7_q, err_q;
  logic [PAGE_W-1:0] off;
  logic              pg_hit, take_new, take_add, take;

  assign off      = addr_i[PAGE_W-1:0];
  assign pg_hit   = addr_i[ADDR_W-1:PAGE_W] == page_q;
  assign take_new = accept_i & ~loading_i;
  assign take_add = accept_i & loading_i & pg_hit;
  assign take     = take_new | take_add;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic              vld_q;
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        byte_q <= '0;
      end else if (take && off == PAGE_W'(g)) begin
        vld_q  <= 1'b1;
        byte_q <= data_i;
      end else if (take_new || commit_i) begin
        vld_q <= 1'b0;
      end
    end
    assign valid_o[g] = vld_q;
    assign bytes_o[g] = byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q    <= '0;
      last_b7_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (take_new) page_q <= addr_i[ADDR_W-1:PAGE_W];
      if (take) last_b7_q <= data_i[DATA_W-1];
      if (accept_i && loading_i && !pg_hit) err_q <= 1'b1;
    end
  end

  assign page_o    = page_q;
  assign last_b7_o = last_b7_q;
  assign err_o     = err_q;

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(err_q));
  // R11
  buf_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(page_q) && $stable(last_b7_q)));
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 7,
  parameter int MIN_PULSE = 2,
  parameter int WINDOW    = 40,
  parameter int PROG_CYC  = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rdata_oe_o,
  output logic              busy_o,
  output logic              page_err_o
);
  localparam int MEM_BYTES  = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;

  logic              act, done, loading, busy, commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [PG_W-1:0]   buf_page;
  logic [PAGE_BYTES-1:0]             buf_valid;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_bytes;
  logic              last_b7, err;

  eep_wr_strobe #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_strobe (
    .clk_i, .rst_ni, .pwr_ok_i, .ce_ni, .oe_ni, .we_ni,
    .addr_i, .data_i(wdata_i),
    .act_o(act), .done_o(done), .addr_o(wr_addr), .data_o(wr_data)
  );

  eep_seq_ctrl #(.WINDOW(WINDOW), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk_i, .rst_ni, .act_i(act), .done_i(done),
    .loading_o(loading), .busy_o(busy), .commit_o(commit)
  );

  eep_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk_i, .rst_ni,
    .accept_i(done & ~busy), .loading_i(loading), .busy_i(busy),
    .commit_i(commit), .addr_i(wr_addr), .data_i(wr_data),
    .page_o(buf_page), .valid_o(buf_valid), .bytes_o(buf_bytes),
    .last_b7_o(last_b7), .err_o(err)
  );

  logic [DATA_W-1:0] mem_q [MEM_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (buf_valid[i]) mem_q[{buf_page, PAGE_W'(i)}] <= buf_bytes[i];
    end
  end

  // read port and polling status
  logic              rd_en, rd_q, rd_start, tog_q, tog_nx;
  logic [DATA_W-1:0] rd_data_q, status;

  assign rd_en    = ~ce_ni & ~oe_ni;
  assign rd_start = rd_en & ~rd_q;
  assign tog_nx   = rd_start ? ~tog_q : tog_q;
  assign status   = {~last_b7, tog_nx, {(DATA_W-2){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      tog_q     <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_q  <= rd_en;
      tog_q <= busy ? tog_nx : 1'b0;
      if (rd_en) rd_data_q <= busy ? status : mem_q[addr_i];
    end
  end

  assign rdata_o    = rd_data_q;
  assign rdata_oe_o = rd_q;
  assign busy_o     = busy;
  assign page_err_o = err;

  // R9
  rd_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> $past(~ce_ni & ~oe_ni));
  // R7
  status_low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_oe_o && $past(busy_o)) |-> rdata_o[DATA_W-3:0] == '0);
endmodule

// File: tb/eeprom_page_seq_tb.sv
`timescale 1ns/1ps
module eeprom_page_seq_tb;
  localparam int AW   = 10;
  localparam int MINP = 2;
  localparam int WIN  = 40;
  localparam int PROG = 60;

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rd_oe, busy, perr;

  always #2.5 clk = ~clk;

  eeprom_page_seq #(.ADDR_W(AW), .PAGE_W(7), .MIN_PULSE(MINP),
                    .WINDOW(WIN), .PROG_CYC(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .ce_ni(ce_n), .oe_ni(oe_n),
    .we_ni(we_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rdata_oe_o(rd_oe), .busy_o(busy), .page_err_o(perr)
  );

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic oe_prev = 1'b0;
  int busy_run = 0, busy_len = 0;
  logic [7:0] e_v;
  string t_v;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on each read result, busy length measurement
  always @(negedge clk) begin
    if (rd_oe === 1'b1 && oe_prev !== 1'b1) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected read", rdata, 0);
      else begin
        e_v = exp_q.pop_front();
        t_v = tag_q.pop_front();
        chk(rdata === e_v, t_v, rdata, e_v);
      end
    end
    oe_prev = rd_oe;
    if (busy === 1'b1) busy_run++;
    else if (busy_run != 0) begin
      busy_len = busy_run;
      busy_run = 0;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    addr = a; wdata = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (hold) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_skew(input logic [AW-1:0] a, input logic [7:0] d,
                         input logic [AW-1:0] a2, input logic [7:0] d2, input int hold);
    @(negedge clk);
    addr = a; wdata = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = a2; wdata = d2;
    repeat (hold - 1) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy !== 1'b1 && t < WIN + 20) begin @(negedge clk); t++; end
    chk(busy === 1'b1, {tag, " programming started"}, busy, 1);
    while (busy === 1'b1) @(negedge clk);
    @(negedge clk);
    chk(busy_len == PROG, "R6 busy length", busy_len, PROG);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_oe == 1'b0, "R9 reset oe", rd_oe, 0);
    chk(busy == 1'b0, "R6 reset busy", busy, 0);
    chk(perr == 1'b0, "R10 reset err", perr, 0);

    rd(10'h005, 8'h00, "R9 read blank");
    chk(rd_oe == 1'b0, "R9 released", rd_oe, 0);

    // R4 R5: three bytes in page 1, gap shorter than the window
    wr(10'h080, 8'h11, 4);
    repeat (WIN - 6) @(negedge clk);
    chk(busy == 1'b0, "R5 no start inside window", busy, 0);
    wr(10'h081, 8'h22, 4);
    wr(10'h0FF, 8'h95, 3);
    for (int k = 1; k <= WIN - 1; k++) begin
      @(negedge clk);
      if (k == WIN - 2) chk(busy == 1'b0, "R5 busy early", busy, 0);
      if (k == WIN - 1) chk(busy == 1'b1, "R5 busy on time", busy, 1);
    end
    // R7 R8: last byte bit7=1 -> status bit7 0; bit6 1,0,1
    rd(10'h080, 8'h40, "R7 R8 first status");
    rd(10'h3FF, 8'h00, "R8 second status");
    wr(10'h080, 8'hEE, 4);  // R11: ignored while busy
    rd(10'h080, 8'h40, "R8 third status");
    wait_idle("R5");
    rd(10'h080, 8'h11, "R11 write during busy ignored");
    rd(10'h081, 8'h22, "R4 second byte");
    rd(10'h0FF, 8'h95, "R4 R6 last byte");
    rd(10'h082, 8'h00, "R4 unloaded byte");
    rd(10'h080, 8'h11, "R8 no toggle after busy");

    // R3: too-short pulse, then minimum pulse
    wr(10'h100, 8'h5A, 1);
    repeat (WIN + 10) @(negedge clk);
    chk(busy == 1'b0, "R3 short pulse no program", busy, 0);
    rd(10'h100, 8'h00, "R3 short pulse dropped");
    wr(10'h100, 8'h5A, MINP);
    wait_idle("R3");
    rd(10'h100, 8'h5A, "R3 min pulse accepted");

    // R1: OE low during strobe, then CE high during strobe
    @(negedge clk);
    addr = 10'h101; wdata = 8'h66; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    exp_q.push_back(8'h00); tag_q.push_back("R1 oe low reads old data");
    repeat (4) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    addr = 10'h102; ce_n = 1'b1; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (WIN + 5) @(negedge clk);
    chk(busy == 1'b0, "R1 no program", busy, 0);
    rd(10'h101, 8'h00, "R1 oe low no write");
    rd(10'h102, 8'h00, "R1 ce high no write");

    // R12: power not good
    pwr_ok = 1'b0;
    wr(10'h103, 8'h77, 4);
    pwr_ok = 1'b1;
    repeat (WIN + 5) @(negedge clk);
    chk(busy == 1'b0, "R12 no program", busy, 0);
    rd(10'h103, 8'h00, "R12 blocked");

    // R2: address at start of overlap, data at end; R7 with bit7=0
    wr_skew(10'h180, 8'h01, 10'h1C0, 8'h3C, 4);
    begin
      int t = 0;
      while (busy !== 1'b1 && t < WIN + 10) begin @(negedge clk); t++; end
    end
    rd(10'h000, 8'hC0, "R7 status complement of bit7 0");
    wait_idle("R2");
    rd(10'h180, 8'h3C, "R2 start address last data");
    rd(10'h1C0, 8'h00, "R2 later address unused");

    // R10: page mismatch
    chk(perr == 1'b0, "R10 clear before", perr, 0);
    wr(10'h200, 8'hA1, 4);
    wr(10'h280, 8'hB2, 4);
    chk(perr == 1'b1, "R10 mismatch flagged", perr, 1);
    wait_idle("R10");
    rd(10'h200, 8'hA1, "R10 first page byte kept");
    rd(10'h280, 8'h00, "R10 mismatched byte dropped");
    chk(perr == 1'b1, "R10 sticky", perr, 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule